// File: doc/BRIEF.md
# Battery Switch Enable Register

This block is a single byte-wide control and status register that sits on the CPU bus and decides whether the charge and discharge switches of a battery pack protection path are on. Software sets three bits: a discharge enable, a charge enable and a bit that turns off deep under-voltage recovery. The block passes these settings into a slow, always-running oscillator domain, where the switch enables and the detector gating signals are produced. While a setting is in transit, and for a short guard time afterwards, further CPU writes are silently dropped.

Hardware can override software in two ways. A current-protection event from the slow domain turns off both switch enables, shows up as a read-only status bit and forces recovery mode off. An internal reset flag from the CPU domain also forces recovery mode off. When recovery mode is allowed, the charge switch is held on whatever the charge enable says.

Register layout (one address): bit 0 charge enable, bit 1 discharge enable, bit 2 protection status (read-only), bit 3 recovery disable, bits 7:4 read as zero.

Top module: `fet_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00, `wr_busy` is low and the outputs are {chg_fet_on,dsg_fet_on,chg_det_en,dsg_det_en} = 4'b1000.
- R2: A write accepted while idle stores bits 3, 1 and 0; writes to bit 2 and bits 7:4 have no effect, and bits 7:4 always read zero.
- R3: The cycle after an accepted write `wr_busy` is high; it stays high until the slow domain has acknowledged the transfer and 3 further CPU cycles have passed; any write while `wr_busy` is high is dropped.
- R4: Bit 2 reads one while `prot_ulp` is high, after a two-stage CPU-clock synchroniser, and zero otherwise.
- R5: When the synchronised protection event rises, bits 1 and 0 are cleared, and this clear wins over a CPU write in the same cycle.
- R6: Bit 3 reads one while protection is active or `int_rst` is high, whatever value is stored.
- R7: `chg_fet_on` is one when the effective recovery-disable bit is zero, or else when the charge enable is one.
- R8: `dsg_fet_on` and `dsg_det_en` both follow the discharge enable; when it is zero all discharge detectors are gated off.
- R9: `chg_det_en` follows the charge enable, and while `prot_ulp` is high all four outputs are low in the slow domain at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | CPU-domain reset, active low |
| ulp_clk | input | 1 | Slow oscillator clock |
| ulp_rst_n | input | 1 | Slow-domain reset, active low |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| int_rst | input | 1 | Internal reset flag, forces recovery off |
| prot_ulp | input | 1 | Current-protection active, slow domain |
| rdata | output | 8 | Register read value |
| wr_busy | output | 1 | Transfer and guard in progress |
| chg_fet_on | output | 1 | Charge switch enable |
| dsg_fet_on | output | 1 | Discharge switch enable |
| chg_det_en | output | 1 | Charge detector gating |
| dsg_det_en | output | 1 | Discharge detector gating |

## Verification
`wr_busy` is due one CPU cycle after an accepted write, so the bench samples it on the following falling edge. Read values and slow-domain outputs are due only after the handshake, the guard and a slow-clock capture, so the driver waits for `wr_busy` to fall plus several slow cycles before pushing an expected item; protection status is due after two CPU synchroniser stages and is checked a few cycles later. Protection shutdown of the outputs is combinational in the slow domain and is checked on the first falling CPU edge after `prot_ulp` is raised.

// File: rtl/fet_ctrl_reg.sv
module fet_ctrl_reg #(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CPU   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ulp_clk,
  input  logic       ulp_rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       int_rst,
  input  logic       prot_ulp,
  output logic [7:0] rdata,
  output logic       wr_busy,
  output logic       chg_fet_on,
  output logic       dsg_fet_on,
  output logic       chg_det_en,
  output logic       dsg_det_en
);

  localparam int GW = $clog2(GUARD_CPU + 1);

  // CPU domain
  logic [SYNC_STAGES-1:0] prot_sync, ack_sync;
  logic                   prot_d, ack_d;
  logic [2:0]             ctl_q;
  logic                   req_q, busy_q, guard_run;
  logic [GW-1:0]          guard_cnt;

  wire prot_s    = prot_sync[SYNC_STAGES-1];
  wire ack_s     = ack_sync[SYNC_STAGES-1];
  wire prot_rise = prot_s & ~prot_d;
  wire ack_edge  = ack_s ^ ack_d;
  wire wr_ok     = wr_en & ~busy_q;
  wire duvrd_eff = ctl_q[2] | prot_s | int_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_sync <= '0;
      ack_sync  <= '0;
      prot_d    <= 1'b0;
      ack_d     <= 1'b0;
      ctl_q     <= 3'b000;
      req_q     <= 1'b0;
      busy_q    <= 1'b0;
      guard_run <= 1'b0;
      guard_cnt <= '0;
    end else begin
      prot_sync <= {prot_sync[SYNC_STAGES-2:0], prot_ulp};
      ack_sync  <= {ack_sync[SYNC_STAGES-2:0], ack_ulp};
      prot_d    <= prot_s;
      ack_d     <= ack_s;
      if (wr_ok) begin
        ctl_q  <= {wdata[3], wdata[1:0]};
        req_q  <= ~req_q;
        busy_q <= 1'b1;
      end
      if (prot_rise) ctl_q[1:0] <= 2'b00;
      if (ack_edge) begin
        guard_run <= 1'b1;
        guard_cnt <= '0;
      end else if (guard_run) begin
        if (guard_cnt == GW'(GUARD_CPU - 1)) begin
          guard_run <= 1'b0;
          busy_q    <= 1'b0;
        end else begin
          guard_cnt <= guard_cnt + 1'b1;
        end
      end
    end
  end

  assign rdata   = {4'b0000, duvrd_eff, prot_s, ctl_q[1:0]};
  assign wr_busy = busy_q;

  // slow domain
  logic [SYNC_STAGES-1:0] req_sync, irst_sync;
  logic                   req_d;
  logic [2:0]             shadow;
  logic                   ack_ulp;

  wire req_s = req_sync[SYNC_STAGES-1];
  wire irst_s = irst_sync[SYNC_STAGES-1];

  always_ff @(posedge ulp_clk or negedge ulp_rst_n) begin
    if (!ulp_rst_n) begin
      req_sync  <= '0;
      irst_sync <= '0;
      req_d     <= 1'b0;
      shadow    <= 3'b000;
    end else begin
      req_sync  <= {req_sync[SYNC_STAGES-2:0], req_q};
      irst_sync <= {irst_sync[SYNC_STAGES-2:0], int_rst};
      req_d     <= req_s;
      if (req_s ^ req_d) shadow <= ctl_q;
      if (prot_ulp) shadow[1:0] <= 2'b00;
    end
  end

  assign ack_ulp = req_d;

  wire duvrd_u = shadow[2] | prot_ulp | irst_s;
  wire dfe_u   = shadow[1] & ~prot_ulp;
  wire cfe_u   = shadow[0] & ~prot_ulp;

  assign chg_fet_on = ~duvrd_u | cfe_u;
  assign dsg_fet_on = dfe_u;
  assign dsg_det_en = dfe_u;
  assign chg_det_en = cfe_u;

  AST_BUSY_SET:   assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !busy_q) |=> busy_q); // R3
  AST_GUARD_DROP: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && busy_q && !prot_rise) |=> $stable(ctl_q)); // R3
  AST_BUSY_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (busy_q && !guard_run) |=> busy_q); // R3
  AST_HW_PRIO:    assert property (@(posedge clk) disable iff (!rst_n) prot_rise |=> (ctl_q[1:0] == 2'b00)); // R5
  AST_PROT_OFF:   assert property (@(posedge ulp_clk) disable iff (!ulp_rst_n) prot_ulp |-> (!chg_fet_on && !dsg_fet_on && !chg_det_en && !dsg_det_en)); // R9

endmodule

// File: tb/fet_ctrl_reg_tb_top.sv
module fet_ctrl_reg_tb_top;
  logic clk = 0, ulp_clk = 0, rst_n = 0, ulp_rst_n = 0;
  logic wr_en = 0, int_rst = 0, prot_ulp = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic wr_busy, chg_fet_on, dsg_fet_on, chg_det_en, dsg_det_en;

  always #10 clk = ~clk;
  always #50 ulp_clk = ~ulp_clk;

  fet_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .ulp_clk(ulp_clk), .ulp_rst_n(ulp_rst_n),
    .wr_en(wr_en), .wdata(wdata), .int_rst(int_rst), .prot_ulp(prot_ulp),
    .rdata(rdata), .wr_busy(wr_busy), .chg_fet_on(chg_fet_on), .dsg_fet_on(dsg_fet_on),
    .chg_det_en(chg_det_en), .dsg_det_en(dsg_det_en)
  );

  typedef struct packed {
    logic [7:0] rd; logic [3:0] f; logic b; logic ur; logic uf; logic ub;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  wire [3:0] fets = {chg_fet_on, dsg_fet_on, chg_det_en, dsg_det_en};

  initial forever begin
    @(negedge clk);
    if (exp_q.size() != 0) begin
      item_t it;
      string t;
      it = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if ((it.ur && rdata !== it.rd) || (it.uf && fets !== it.f) || (it.ub && wr_busy !== it.b)) begin
        miscompares++;
        $display("FAIL %s: actual rdata=%h outs=%b busy=%b expected rdata=%h outs=%b busy=%b",
                 t, rdata, fets, wr_busy, it.rd, it.f, it.b);
      end
    end
  end

  task automatic expect_item(string t, logic [7:0] rd, logic [3:0] f, logic b,
                             logic ur, logic uf, logic ub);
    exp_q.push_back('{rd: rd, f: f, b: b, ur: ur, uf: uf, ub: ub});
    tag_q.push_back(t);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wdata = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (wr_busy) @(negedge clk);
    repeat (5) @(posedge ulp_clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge ulp_clk);
    rst_n = 1; ulp_rst_n = 1;
    @(negedge clk);
    expect_item("R1 reset", 8'h00, 4'b1000, 1'b0, 1, 1, 1);

    for (int i = 0; i < 8; i++) begin
      logic d, e, c;
      d = i[2]; e = i[1]; c = i[0];
      wr({4'b0000, d, 1'b0, e, c});
      expect_item("R3 busy after write", 8'h00, 4'b0000, 1'b1, 0, 0, 1);
      wait_idle();
      expect_item("R2 R7 R8 R9 gating", {4'b0000, d, 1'b0, e, c}, {~d | c, e, c, e}, 1'b0, 1, 1, 1);
    end

    wr(8'hFF);
    wait_idle();
    expect_item("R2 reserved bits", 8'h0B, 4'b1111, 1'b0, 1, 1, 0);
    wr(8'h04);
    wait_idle();
    expect_item("R2 status bit not writable", 8'h00, 4'b1000, 1'b0, 1, 1, 0);

    @(negedge clk); wr_en = 1; wdata = 8'h0A;
    @(negedge clk); wdata = 8'h01;
    @(negedge clk); wr_en = 0;
    wait_idle();
    expect_item("R3 write in guard dropped", 8'h0A, 4'b0101, 1'b0, 1, 1, 0);
    wr(8'h03);
    expect_item("R3 write after guard accepted", 8'h00, 4'b0000, 1'b1, 0, 0, 1);
    wait_idle();
    expect_item("R3 R7 recovery plus enables", 8'h03, 4'b1111, 1'b0, 1, 1, 0);

    @(negedge ulp_clk); prot_ulp = 1;
    @(negedge clk);
    expect_item("R9 protection shuts outputs", 8'h00, 4'b0000, 1'b0, 0, 1, 0);
    repeat (4) @(negedge clk);
    expect_item("R4 R5 R6 protection status", 8'h0C, 4'b0000, 1'b0, 1, 1, 0);
    @(negedge ulp_clk); prot_ulp = 0;
    repeat (5) @(posedge ulp_clk);
    @(negedge clk);
    expect_item("R4 R5 after protection", 8'h00, 4'b1000, 1'b0, 1, 1, 0);

    @(negedge clk); int_rst = 1;
    repeat (4) @(posedge ulp_clk);
    @(negedge clk);
    expect_item("R6 internal reset forces bit3", 8'h08, 4'b0000, 1'b0, 1, 1, 0);
    @(negedge clk); int_rst = 0;
    repeat (4) @(posedge ulp_clk);
    @(negedge clk);
    expect_item("R6 R7 internal reset released", 8'h00, 4'b1000, 1'b0, 1, 1, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule